// File: doc/BRIEF.md
# Special-Register Access and Reserved-Field Classifier

This block decides whether a request that touches a special-purpose register, or an instruction word checked for reserved bits, may go ahead. It returns one of three verdicts: allow, raise an illegal-instruction exception, or raise a privileged-instruction exception. An upstream decoder presents one request per cycle. The request carries an operation code, the privilege mode and either a 10-bit register number or an instruction word. For a word, the decoder also gives the mask of its reserved bit positions and a form code. The verdict appears one clock later on three one-hot outputs.

Each register has three attributes: defined, privileged and read-only. They come from three parameter bit vectors indexed by register number. A register number with bit 4 set lies in the privileged range. The block uses that range to decide how an undefined register is treated. Two kinds of reserved bits never trap: the lowest word bit of an indexed integer load/store, and the branch option field at word bits 25:21.

Top module: `spr_access_classifier`

## Requirements
- R1: The verdict is registered. `res_valid` and the verdict bits follow a request by exactly one clock. During reset and on the cycle after reset all outputs are 0.
- R2: While `res_valid` is 1, exactly one of `res_allow`, `res_illegal` and `res_priv` is 1. While it is 0, all three are 0.
- R3: A read (op 0) or a write (op 1) in user mode (`req_user`=1) to a defined register whose privileged attribute is set gives `res_priv`.
- R4: An access to an undefined register gives a result that depends on the number and the mode. If the number has bit 4 set and the mode is user, the result is `res_priv`. In every other case the result is `res_illegal`.
- R5: A write to a defined register that is read-only and not privileged gives `res_illegal` in both modes. A read of the same register gives `res_allow`.
- R6: A write to a defined register that is read-only and privileged gives `res_priv` in user mode and `res_illegal` in supervisor mode.
- R7: All other accesses to defined registers give `res_allow`. This covers reads and writes of writable registers and any supervisor access to a privileged register that is not a read-only write.
- R8: For an instruction check (op 2), the result is `res_illegal` if any bit set in `insn_rsv_mask` is also set in `insn_word`, after the exemptions of R9 and R10. Otherwise the result is `res_allow`. Form codes 0 and 3 have no exemption. Op 3 always gives `res_illegal`.
- R9: With form code 1 (indexed integer load/store), `insn_word[0]` is ignored even when it is marked reserved.
- R10: With form code 2 (conditional branch), `insn_word[25:21]` (the branch option field) is ignored even where it is marked reserved.
- R11: The default attribute table is as follows:
  - Defined registers: 1, 8, 9, 26, 27, 268, 269, 272–275, 286, 287 and 1023. All other numbers are undefined.
  - Privileged registers: 26, 27, 272–275, 286, 287 and 1023.
  - Read-only registers: 268, 269, 286, 287 and 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read register, 1 write register, 2 instruction check, 3 reserved |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| spr_num | input | 10 | Special register number |
| insn_word | input | 32 | Instruction word to check |
| insn_form | input | 2 | 0 plain, 1 indexed load/store, 2 conditional branch, 3 plain |
| insn_rsv_mask | input | 32 | 1 marks a reserved bit position of `insn_word` |
| res_valid | output | 1 | Verdict present |
| res_allow | output | 1 | Access or instruction may proceed |
| res_illegal | output | 1 | Raise illegal-instruction exception |
| res_priv | output | 1 | Raise privileged-instruction exception |

## Verification
The bench builds the block with its default parameters: a 10-bit register number, bit 4 as the privileged-range bit, and the R11 table. Under that table every attribute combination occurs. There are writable user registers and read-only user registers. There are writable privileged registers and read-only privileged registers. There are undefined numbers on both sides of the privileged range. This lets each rule be reached in both modes. Instruction checks place set bits on and next to both exempt positions under every form code.

// File: rtl/sprchk_pkg.sv
// Shared types and default attribute tables for the special-register
// access classifier. Assumes the default register-number width of 10 bits.
package sprchk_pkg;

    localparam int DFLT_SPR_W = 10;
    localparam int DFLT_NUM   = 1 << DFLT_SPR_W;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_INSN  = 2'd2,
        OP_SPARE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FORM_PLAIN  = 2'd0,
        FORM_LDST_X = 2'd1,
        FORM_BRANCH = 2'd2,
        FORM_SPARE  = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'd0,
        VERD_ILLEGAL = 2'd1,
        VERD_PRIV    = 2'd2
    } verdict_e;

    // Default set of defined register numbers.
    function automatic logic [DFLT_NUM-1:0] dflt_defined();
        logic [DFLT_NUM-1:0] m;
        m = '0;
        m[1] = 1'b1;  m[8] = 1'b1;  m[9] = 1'b1;
        m[26] = 1'b1; m[27] = 1'b1;
        m[268] = 1'b1; m[269] = 1'b1;
        for (int i = 272; i <= 275; i++) m[i] = 1'b1;
        m[286] = 1'b1; m[287] = 1'b1; m[1023] = 1'b1;
        return m;
    endfunction

    // Default set of privileged register numbers.
    function automatic logic [DFLT_NUM-1:0] dflt_priv();
        logic [DFLT_NUM-1:0] m;
        m = '0;
        m[26] = 1'b1; m[27] = 1'b1;
        for (int i = 272; i <= 275; i++) m[i] = 1'b1;
        m[286] = 1'b1; m[287] = 1'b1; m[1023] = 1'b1;
        return m;
    endfunction

    // Default set of read-only register numbers.
    function automatic logic [DFLT_NUM-1:0] dflt_ro();
        logic [DFLT_NUM-1:0] m;
        m = '0;
        m[268] = 1'b1; m[269] = 1'b1;
        m[286] = 1'b1; m[287] = 1'b1; m[1023] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/spr_attr_lookup.sv
// Looks up the three attribute bits of one register number in the
// parameter tables. Purely combinational; assumes tables cover every number.
module spr_attr_lookup #(
    parameter int                      SPR_W    = 10,
    parameter logic [(1<<SPR_W)-1:0]   DEF_MASK = sprchk_pkg::dflt_defined(),
    parameter logic [(1<<SPR_W)-1:0]   PRV_MASK = sprchk_pkg::dflt_priv(),
    parameter logic [(1<<SPR_W)-1:0]   RO_MASK  = sprchk_pkg::dflt_ro()
) (
    input  logic [SPR_W-1:0] num,
    output logic             is_defined,
    output logic             is_priv,
    output logic             is_ro
);
    // Index each table with the register number.
    always_comb begin
        is_defined = DEF_MASK[num];
        is_priv    = PRV_MASK[num];
        is_ro      = RO_MASK[num];
    end
endmodule

// File: rtl/spr_access_rules.sv
// Applies the privilege, definition and read-only rules to one register
// access. Assumes op is a read or a write; the caller selects the result.
module spr_access_rules
    import sprchk_pkg::*;
#(
    parameter int SPR_W   = 10,
    parameter int PRV_BIT = 4
) (
    input  logic [SPR_W-1:0] num,
    input  logic             is_write,
    input  logic             user_mode,
    input  logic             is_defined,
    input  logic             is_priv,
    input  logic             is_ro,
    output verdict_e         verdict
);
    logic in_priv_range;

    // Register numbers with the range bit set count as privileged when undefined.
    always_comb in_priv_range = num[PRV_BIT];

    // Ordered rule chain: undefined, privilege, read-only write, allow.
    always_comb begin
        if (!is_defined) begin
            verdict = (in_priv_range && user_mode) ? VERD_PRIV : VERD_ILLEGAL;
        end else if (is_priv && user_mode) begin
            verdict = VERD_PRIV;
        end else if (is_write && is_ro) begin
            verdict = VERD_ILLEGAL;
        end else begin
            verdict = VERD_ALLOW;
        end
    end
endmodule

// File: rtl/rsvd_field_check.sv
// Flags an instruction word that has a set bit in a reserved position,
// after removing the exempt positions of its form. Combinational.
module rsvd_field_check
    import sprchk_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int LDST_BIT = 0,
    parameter int BO_LSB   = 21,
    parameter int BO_W     = 5
) (
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] rsv_mask,
    input  logic [1:0]        form,
    output logic              hit
);
    localparam logic [WORD_W-1:0] LDST_EXEMPT = WORD_W'(1) << LDST_BIT;
    localparam logic [WORD_W-1:0] BO_EXEMPT   = ((WORD_W'(1) << BO_W) - WORD_W'(1)) << BO_LSB;

    logic [WORD_W-1:0] exempt;
    logic [WORD_W-1:0] live_mask;

    // Pick the exempt positions for the presented form.
    always_comb begin
        unique case (form_e'(form))
            FORM_LDST_X: exempt = LDST_EXEMPT;
            FORM_BRANCH: exempt = BO_EXEMPT;
            default:     exempt = '0;
        endcase
    end

    // Any reserved, non-exempt bit that is set trips the check.
    always_comb begin
        live_mask = rsv_mask & ~exempt;
        hit       = |(word & live_mask);
    end
endmodule

// File: rtl/spr_access_classifier.sv
// Top of the special-register access classifier. Combines the register
// rules and the reserved-field check, then registers a one-hot verdict.
// Assumes one request per cycle and a synchronous active-low reset.
module spr_access_classifier
    import sprchk_pkg::*;
#(
    parameter int                      SPR_W    = 10,
    parameter int                      PRV_BIT  = 4,
    parameter int                      WORD_W   = 32,
    parameter logic [(1<<SPR_W)-1:0]   DEF_MASK = sprchk_pkg::dflt_defined(),
    parameter logic [(1<<SPR_W)-1:0]   PRV_MASK = sprchk_pkg::dflt_priv(),
    parameter logic [(1<<SPR_W)-1:0]   RO_MASK  = sprchk_pkg::dflt_ro()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_user,
    input  logic [SPR_W-1:0]  spr_num,
    input  logic [WORD_W-1:0] insn_word,
    input  logic [1:0]        insn_form,
    input  logic [WORD_W-1:0] insn_rsv_mask,
    output logic              res_valid,
    output logic              res_allow,
    output logic              res_illegal,
    output logic              res_priv
);
    logic     a_def, a_priv, a_ro;
    logic     rsv_hit;
    verdict_e spr_verdict;
    verdict_e next_verdict;

    spr_attr_lookup #(
        .SPR_W(SPR_W), .DEF_MASK(DEF_MASK), .PRV_MASK(PRV_MASK), .RO_MASK(RO_MASK)
    ) lookup_i (
        .num(spr_num), .is_defined(a_def), .is_priv(a_priv), .is_ro(a_ro)
    );

    spr_access_rules #(
        .SPR_W(SPR_W), .PRV_BIT(PRV_BIT)
    ) rules_i (
        .num(spr_num), .is_write(req_op == OP_WRITE), .user_mode(req_user),
        .is_defined(a_def), .is_priv(a_priv), .is_ro(a_ro), .verdict(spr_verdict)
    );

    rsvd_field_check #(
        .WORD_W(WORD_W)
    ) rsvd_i (
        .word(insn_word), .rsv_mask(insn_rsv_mask), .form(insn_form), .hit(rsv_hit)
    );

    // Choose the verdict source from the operation code.
    always_comb begin
        unique case (op_e'(req_op))
            OP_READ, OP_WRITE: next_verdict = spr_verdict;
            OP_INSN:           next_verdict = rsv_hit ? VERD_ILLEGAL : VERD_ALLOW;
            default:           next_verdict = VERD_ILLEGAL;
        endcase
    end

    // Register the one-hot verdict; clear it on reset or idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_allow   <= 1'b0;
            res_illegal <= 1'b0;
            res_priv    <= 1'b0;
        end else begin
            res_valid   <= req_valid;
            res_allow   <= req_valid && (next_verdict == VERD_ALLOW);
            res_illegal <= req_valid && (next_verdict == VERD_ILLEGAL);
            res_priv    <= req_valid && (next_verdict == VERD_PRIV);
        end
    end

    // R2: one verdict exactly while valid, none otherwise.
    assert_onehot_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_allow, res_illegal, res_priv}) == (res_valid ? 1 : 0));

    // R1: result appears one clock after the request.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R6/R4: supervisor requests never produce a privileged verdict.
    assert_super_no_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user) |=> !res_priv);

    // R5: read-only, non-privileged writes never pass.
    assert_ro_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_WRITE && a_def && a_ro && !a_priv) |=> res_illegal);

    // R9: an indexed load/store with only bit 0 reserved and set is allowed.
    assert_ldst_exempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_INSN && insn_form == FORM_LDST_X
         && ((insn_word & insn_rsv_mask) == WORD_W'(1))) |=> res_allow);

    // R3: user access to a defined privileged register traps as privileged.
    assert_user_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && (req_op == OP_READ || req_op == OP_WRITE)
         && a_def && a_priv) |=> res_priv);
endmodule

// File: tb/spr_access_classifier_tb_top.sv
module spr_access_classifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_user = 1'b0;
    logic [9:0]  spr_num = '0;
    logic [31:0] insn_word = '0;
    logic [1:0]  insn_form = 2'd0;
    logic [31:0] insn_rsv_mask = '0;
    logic        res_valid, res_allow, res_illegal, res_priv;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [3:0] exp_out = 4'b0;   // {valid, allow, illegal, priv}
    string      exp_tag = "R1";

    always #2.5 clk = ~clk;

    spr_access_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_user(req_user), .spr_num(spr_num), .insn_word(insn_word),
        .insn_form(insn_form), .insn_rsv_mask(insn_rsv_mask),
        .res_valid(res_valid), .res_allow(res_allow),
        .res_illegal(res_illegal), .res_priv(res_priv)
    );

    // Reference attribute table written from R11.
    function automatic bit m_def(int n);
        return n inside {1, 8, 9, 26, 27, 268, 269, [272:275], 286, 287, 1023};
    endfunction
    function automatic bit m_priv(int n);
        return n inside {26, 27, [272:275], 286, 287, 1023};
    endfunction
    function automatic bit m_ro(int n);
        return n inside {268, 269, 286, 287, 1023};
    endfunction

    localparam logic [3:0] V_ALLOW = 4'b1100;
    localparam logic [3:0] V_ILL   = 4'b1010;
    localparam logic [3:0] V_PRIV  = 4'b1001;

    // Behavioural model: expected verdict and the requirement it exercises.
    task automatic model(input bit v, input int op, input bit usr, input int n,
                         input logic [31:0] w, input int form, input logic [31:0] m,
                         output logic [3:0] e, output string tag);
        logic [31:0] eff;
        if (!v) begin e = 4'b0000; tag = "R2"; return; end
        if (op == 3) begin e = V_ILL; tag = "R8"; return; end
        if (op == 2) begin
            eff = m;
            tag = "R8";
            if (form == 1) begin eff[0] = 1'b0; tag = "R9"; end
            if (form == 2) begin eff[25:21] = 5'b0; tag = "R10"; end
            e = ((w & eff) != 0) ? V_ILL : V_ALLOW;
            return;
        end
        if (!m_def(n)) begin
            tag = "R4";
            e = (((n >> 4) & 1) == 1 && usr) ? V_PRIV : V_ILL;
        end else if (m_priv(n) && usr) begin
            tag = (op == 1 && m_ro(n)) ? "R6" : "R3";
            e = V_PRIV;
        end else if (op == 1 && m_ro(n)) begin
            tag = m_priv(n) ? "R6" : "R5";
            e = V_ILL;
        end else begin
            tag = m_ro(n) ? "R5" : "R7";
            e = V_ALLOW;
        end
    endtask

    task automatic compare();
        logic [3:0] got;
        got = {res_valid, res_allow, res_illegal, res_priv};
        n_cmp++;
        if (got !== exp_out) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (valid,allow,illegal,priv)",
                     exp_tag, got, exp_out);
        end
    endtask

    // Compare the previous verdict, then present the next request.
    task automatic apply(input bit v, input int op, input bit usr, input int n,
                         input logic [31:0] w, input int form, input logic [31:0] m);
        logic [3:0] e;
        string t;
        @(negedge clk);
        compare();
        req_valid = v; req_op = op[1:0]; req_user = usr; spr_num = n[9:0];
        insn_word = w; insn_form = form[1:0]; insn_rsv_mask = m;
        model(v, op, usr, n, w, form, m, e, t);
        exp_out = e; exp_tag = t;
    endtask

    initial begin
        int picks[16] = '{1, 8, 9, 26, 27, 268, 269, 272, 275, 286, 287, 1023, 2, 16, 300, 1008};
        // R1: outputs stay clear in reset and right after it.
        exp_out = 4'b0; exp_tag = "R1";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        compare();
        // R3: user read of privileged register.
        apply(1, 0, 1, 26, 0, 0, 0);
        // R7: supervisor read and write of privileged register, user rw register.
        apply(1, 1, 0, 272, 0, 0, 0);
        apply(1, 1, 1, 8, 0, 0, 0);
        // R4: undefined in privileged range and outside it.
        apply(1, 0, 1, 16, 0, 0, 0);
        apply(1, 0, 0, 16, 0, 0, 0);
        apply(1, 1, 1, 2, 0, 0, 0);
        // R5: read-only user register.
        apply(1, 1, 0, 268, 0, 0, 0);
        apply(1, 1, 1, 269, 0, 0, 0);
        apply(1, 0, 1, 268, 0, 0, 0);
        // R6: read-only privileged register.
        apply(1, 1, 1, 286, 0, 0, 0);
        apply(1, 1, 0, 1023, 0, 0, 0);
        // R8: plain reserved hit and miss, spare op.
        apply(1, 2, 0, 0, 32'h0000_0800, 0, 32'h0000_0800);
        apply(1, 2, 0, 0, 32'h0000_0800, 0, 32'h0000_0001);
        apply(1, 3, 0, 0, 0, 0, 0);
        // R9: bit 0 exempt for indexed load/store, bit 1 not.
        apply(1, 2, 1, 0, 32'h0000_0001, 1, 32'h0000_0001);
        apply(1, 2, 1, 0, 32'h0000_0003, 1, 32'h0000_0003);
        apply(1, 2, 1, 0, 32'h0000_0001, 0, 32'h0000_0001);
        // R10: branch option field exempt, neighbours not.
        apply(1, 2, 0, 0, 32'h03E0_0000, 2, 32'h03E0_0000);
        apply(1, 2, 0, 0, 32'h0410_0000, 2, 32'h0410_0000);
        apply(1, 2, 0, 0, 32'h03E0_0000, 3, 32'h03E0_0000);
        // R2: idle cycle.
        apply(0, 0, 0, 26, 0, 0, 0);
        // Random mix across all rules.
        for (int k = 0; k < 3000; k++) begin
            int n;
            int op;
            logic [31:0] w, m;
            n  = ($urandom_range(0, 9) < 6) ? picks[$urandom_range(0, 15)] : int'($urandom_range(0, 1023));
            op = $urandom_range(0, 3);
            w  = $urandom;
            m  = $urandom & $urandom & $urandom;
            if ($urandom_range(0, 3) == 0) m = m & 32'h03E0_0001;
            apply($urandom_range(0, 7) != 0, op, $urandom_range(0, 1), n, w,
                  $urandom_range(0, 3), m);
        end
        apply(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1: watchdog expired, got no end expected end");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule